// File: doc/BRIEF.md
# Common Interrupt Distribution Unit

This block spreads a set of shared interrupt sources across the interrupt inputs of several cores. Every source has its own settings: a core bitmask that lists the cores it may reach, a distribution mode, and a mask bit. In fixed mode an asserted source drives the line of every core in its bitmask. In rotating mode each new assertion goes to a single core, and the choice moves to the next listed core each time the source rises again. This spreads interrupt load across the listed cores.

All settings are written through one command port. Each command is an opcode, a source index and a 32-bit data word, and takes effect on the clock edge that accepts it. A one-shot enable command switches delivery on. Until that command arrives, and for every source that is masked, no output line is raised. The output bus holds one line per source per core. Source `i` for core `c` sits at bit `c*NUM_SRC + i`, so each core sees the shared sources as a contiguous group of its external interrupt lines. Outputs are registered and follow the inputs with one cycle of latency.

Top module: `common_irq_dist`

## Requirements
- R1: After reset every output line is low, every source is masked and delivery is disabled, so raised inputs produce no output.
- R2: Opcode 4 switches delivery on. Before that command has taken effect, no output line is asserted, even for unmasked sources with raised inputs.
- R3: Opcode 3 writes the mask bit of the indexed source from data bit 0. A value of 1 masks the source and a value of 0 unmasks it. A masked source drives no line.
- R4: Opcode 1 writes the core bitmask of the indexed source from data bits [NUM_CORE-1:0]. In fixed mode, the line for core `c` (bit `c*NUM_SRC+i`) equals the source input ANDed with mask bit `c`, one cycle after the input.
- R5: Opcode 2 writes the mode of the indexed source from data bits [1:0]. The value 1 selects rotating mode, and the values 0, 2 and 3 select fixed mode. All other data bits are ignored.
- R6: Inputs are level-sensitive. A line stays high while its source input is high, and it falls one cycle after the input falls.
- R7: In rotating mode, each low-to-high input transition is delivered to the next core set in the bitmask, searching upward from the last served core and wrapping. The first delivery after reset goes to the lowest set core. At most one line of the source is high at a time.
- R8: The rotation choice advances only on a rising input. While the input stays high, the same core keeps its line.
- R9: A source whose bitmask is all zero reaches no core. A rise seen while the mask is empty does not move the rotation.
- R10: A bitmask write made while a source is asserted changes the routing on the next cycle. In rotating mode the held core stays asserted only if it is still in the new bitmask.
- R11: A command with index `i` changes only the settings of source `i`. The other sources keep their routing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command strobe, one command per cycle |
| cmd_op | input | 3 | Opcode: 1 core bitmask, 2 mode, 3 mask, 4 enable |
| cmd_idx | input | IDX_W | Source index the command applies to |
| cmd_data | input | 32 | Command data word |
| irq_in | input | NUM_SRC | Shared interrupt inputs, level-sensitive |
| irq_out | output | NUM_SRC*NUM_CORE | Per-core lines, bit c*NUM_SRC+i for source i, core c |

## Verification
The hardest case to reach from the ports is a rotation that wraps around a sparse bitmask. The same test also has to show that a rise seen with an empty bitmask leaves the rotation where it was. The bench gets there by pulsing one rotating source many times. It holds the input for two cycles and then drops it for one, and it rewrites that source's bitmask between pulse trains: first all cores, then empty, then a single core, then two non-adjacent cores. During these trains the other sources stay asserted in fixed mode, so any change that leaks between sources shows up on their lines.

// File: rtl/idu_pkg.sv
package idu_pkg;
  localparam int CMD_DATA_W = 32;

  typedef enum logic [2:0] {
    OP_NOP    = 3'd0,
    OP_DEST   = 3'd1,
    OP_MODE   = 3'd2,
    OP_MASK   = 3'd3,
    OP_ENABLE = 3'd4
  } idu_op_e;

  localparam logic [1:0] DIST_ROTATE = 2'd1;
endpackage

// File: rtl/idu_cfg_regs.sv
module idu_cfg_regs
  import idu_pkg::*;
#(
  parameter int NUM_SRC  = 4,
  parameter int NUM_CORE = 4,
  parameter int IDX_W    = 2
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         cmd_valid,
  input  logic [2:0]                   cmd_op,
  input  logic [IDX_W-1:0]             cmd_idx,
  input  logic [CMD_DATA_W-1:0]        cmd_data,
  output logic                         dist_en,
  output logic [NUM_SRC-1:0]           src_masked,
  output logic [NUM_SRC-1:0]           src_rotate,
  output logic [NUM_SRC*NUM_CORE-1:0]  src_dest
);

  logic en_q;
  logic idx_ok;

  assign idx_ok = (int'(cmd_idx) < NUM_SRC);

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q <= 1'b0;
    end else if (cmd_valid && idu_op_e'(cmd_op) == OP_ENABLE) begin
      en_q <= 1'b1;
    end
  end

  assign dist_en = en_q;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    logic                hit;
    logic                mask_q;
    logic                rot_q;
    logic [NUM_CORE-1:0] dest_q;

    assign hit = cmd_valid && idx_ok && (int'(cmd_idx) == i);

    always_ff @(posedge clk) begin
      if (rst) begin
        mask_q <= 1'b1;
        rot_q  <= 1'b0;
        dest_q <= '0;
      end else if (hit) begin
        case (idu_op_e'(cmd_op))
          OP_DEST: dest_q <= cmd_data[NUM_CORE-1:0];
          OP_MODE: rot_q  <= (cmd_data[1:0] == DIST_ROTATE);
          OP_MASK: mask_q <= cmd_data[0];
          default: ;
        endcase
      end
    end

    assign src_masked[i] = mask_q;
    assign src_rotate[i] = rot_q;
    assign src_dest[i*NUM_CORE +: NUM_CORE] = dest_q;
  end

  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (src_masked == {NUM_SRC{1'b1}} && !dist_en));

  // R11
  idle_cfg_chk: assert property (@(posedge clk) disable iff (rst)
    !cmd_valid |=> ($stable(src_masked) && $stable(src_dest) && $stable(src_rotate)));

endmodule

// File: rtl/idu_rr_pick.sv
module idu_rr_pick #(
  parameter int NUM_CORE = 4,
  parameter int PTR_W    = 2
) (
  input  logic [NUM_CORE-1:0] dest,
  input  logic [PTR_W-1:0]    last,
  output logic [PTR_W-1:0]    next_idx,
  output logic                found
);

  always_comb begin
    found    = 1'b0;
    next_idx = last;
    for (int k = 1; k <= NUM_CORE; k++) begin
      int cand;
      cand = int'(last) + k;
      if (cand >= NUM_CORE) cand = cand - NUM_CORE;
      if (!found && dest[cand]) begin
        found    = 1'b1;
        next_idx = PTR_W'(cand);
      end
    end
  end

endmodule

// File: rtl/idu_src_lane.sv
module idu_src_lane #(
  parameter int NUM_CORE = 4,
  parameter int PTR_W    = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                dist_en,
  input  logic                masked,
  input  logic                rotate,
  input  logic [NUM_CORE-1:0] dest,
  input  logic                level,
  output logic [NUM_CORE-1:0] lines
);

  logic                prev_q;
  logic [PTR_W-1:0]    ptr_q;
  logic [PTR_W-1:0]    ptr_d;
  logic [PTR_W-1:0]    pick_idx;
  logic                pick_found;
  logic                active;
  logic                rise;
  logic                advance;
  logic [NUM_CORE-1:0] sel;
  logic [NUM_CORE-1:0] lines_d;
  logic [NUM_CORE-1:0] lines_q;

  idu_rr_pick #(.NUM_CORE(NUM_CORE), .PTR_W(PTR_W)) u_pick (
    .dest     (dest),
    .last     (ptr_q),
    .next_idx (pick_idx),
    .found    (pick_found)
  );

  assign active  = dist_en && !masked;
  assign rise    = level && !prev_q;
  assign advance = active && rotate && rise && pick_found;
  assign ptr_d   = advance ? pick_idx : ptr_q;

  for (genvar c = 0; c < NUM_CORE; c++) begin : g_sel
    assign sel[c] = (int'(ptr_d) == c);
  end

  always_comb begin
    lines_d = '0;
    if (active && level) begin
      lines_d = rotate ? (sel & dest) : dest;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q  <= 1'b0;
      ptr_q   <= PTR_W'(NUM_CORE - 1);
      lines_q <= '0;
    end else begin
      prev_q  <= level;
      ptr_q   <= ptr_d;
      lines_q <= lines_d;
    end
  end

  assign lines = lines_q;

  // R3
  masked_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    masked |=> (lines == '0));

  // R6
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !level |=> (lines == '0));

  // R7
  rr_single_chk: assert property (@(posedge clk) disable iff (rst)
    rotate |=> $onehot0(lines));

  // R8
  ptr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !rise |=> $stable(ptr_q));

  // R4
  direct_route_chk: assert property (@(posedge clk) disable iff (rst)
    (active && level && !rotate) |=> (lines == $past(dest)));

  // R9
  empty_dest_chk: assert property (@(posedge clk) disable iff (rst)
    (dest == '0) |=> (lines == '0 && $stable(ptr_q)));

endmodule

// File: rtl/common_irq_dist.sv
module common_irq_dist
  import idu_pkg::*;
#(
  parameter int NUM_SRC  = 4,
  parameter int NUM_CORE = 4,
  localparam int IDX_W   = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         cmd_valid,
  input  logic [2:0]                   cmd_op,
  input  logic [IDX_W-1:0]             cmd_idx,
  input  logic [31:0]                  cmd_data,
  input  logic [NUM_SRC-1:0]           irq_in,
  output logic [NUM_SRC*NUM_CORE-1:0]  irq_out
);

  localparam int PTR_W = (NUM_CORE > 1) ? $clog2(NUM_CORE) : 1;

  logic                        dist_en;
  logic [NUM_SRC-1:0]          src_masked;
  logic [NUM_SRC-1:0]          src_rotate;
  logic [NUM_SRC*NUM_CORE-1:0] src_dest;

  idu_cfg_regs #(
    .NUM_SRC  (NUM_SRC),
    .NUM_CORE (NUM_CORE),
    .IDX_W    (IDX_W)
  ) u_cfg (
    .clk        (clk),
    .rst        (rst),
    .cmd_valid  (cmd_valid),
    .cmd_op     (cmd_op),
    .cmd_idx    (cmd_idx),
    .cmd_data   (cmd_data),
    .dist_en    (dist_en),
    .src_masked (src_masked),
    .src_rotate (src_rotate),
    .src_dest   (src_dest)
  );

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_lane
    logic [NUM_CORE-1:0] lane_lines;

    idu_src_lane #(.NUM_CORE(NUM_CORE), .PTR_W(PTR_W)) u_lane (
      .clk     (clk),
      .rst     (rst),
      .dist_en (dist_en),
      .masked  (src_masked[i]),
      .rotate  (src_rotate[i]),
      .dest    (src_dest[i*NUM_CORE +: NUM_CORE]),
      .level   (irq_in[i]),
      .lines   (lane_lines)
    );

    for (genvar c = 0; c < NUM_CORE; c++) begin : g_core
      assign irq_out[c*NUM_SRC + i] = lane_lines[c];
    end
  end

  // R2
  no_enable_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !dist_en |=> (irq_out == '0));

endmodule

// File: tb/common_irq_dist_test.sv
`timescale 1ns/1ps
module common_irq_dist_test;
  localparam int C  = 4;
  localparam int N  = 4;
  localparam int IW = 2;

  logic           clk = 1'b0;
  logic           rst;
  logic           cmd_valid;
  logic [2:0]     cmd_op;
  logic [IW-1:0]  cmd_idx;
  logic [31:0]    cmd_data;
  logic [C-1:0]   irq_in;
  logic [C*N-1:0] irq_out;

  always #4 clk = ~clk;

  common_irq_dist #(.NUM_SRC(C), .NUM_CORE(N)) uut (
    .clk       (clk),
    .rst       (rst),
    .cmd_valid (cmd_valid),
    .cmd_op    (cmd_op),
    .cmd_idx   (cmd_idx),
    .cmd_data  (cmd_data),
    .irq_in    (irq_in),
    .irq_out   (irq_out)
  );

  typedef struct {
    logic [C*N-1:0] exp;
    string          tag;
  } item_t;

  item_t sb_q[$];
  int checks = 0;
  int errors = 0;
  bit done = 0;

  // reference state built from the requirements
  bit         m_en;
  bit [C-1:0] m_mask;
  bit [N-1:0] m_dest [C];
  bit         m_rot  [C];
  int         m_ptr  [C];
  bit [C-1:0] m_prev;

  task automatic cycle(input logic [2:0] op, input int idx, input logic [31:0] data,
                       input logic [C-1:0] vec, input string tag);
    item_t it;
    logic [C*N-1:0] e;
    e = '0;
    cmd_valid = (op != 3'd0);
    cmd_op    = op;
    cmd_idx   = IW'(idx);
    cmd_data  = data;
    irq_in    = vec;
    for (int i = 0; i < C; i++) begin
      bit act;
      act = m_en && !m_mask[i];
      if (m_rot[i] && act && vec[i] && !m_prev[i] && m_dest[i] != '0) begin
        for (int k = 1; k <= N; k++) begin
          int cc;
          cc = (m_ptr[i] + k) % N;
          if (m_dest[i][cc]) begin
            m_ptr[i] = cc;
            break;
          end
        end
      end
      for (int c = 0; c < N; c++) begin
        if (act && vec[i])
          e[c*C+i] = m_rot[i] ? (m_ptr[i] == c && m_dest[i][c]) : m_dest[i][c];
      end
      m_prev[i] = vec[i];
    end
    case (op)
      3'd1: m_dest[idx] = data[N-1:0];
      3'd2: m_rot[idx]  = (data[1:0] == 2'd1);
      3'd3: m_mask[idx] = data[0];
      3'd4: m_en = 1'b1;
      default: ;
    endcase
    it.exp = e;
    it.tag = tag;
    sb_q.push_back(it);
    @(negedge clk);
  endtask

  task automatic hold(input logic [C-1:0] vec, input int n, input string tag);
    for (int j = 0; j < n; j++) cycle(3'd0, 0, 32'd0, vec, tag);
  endtask

  // monitor: compare each result one step after its posedge
  initial begin
    item_t it;
    forever begin
      @(posedge clk);
      #2;
      if (sb_q.size() > 0) begin
        it = sb_q.pop_front();
        checks++;
        if (irq_out !== it.exp) begin
          errors++;
          $display("FAIL %s: irq_out=%h expected %h at %0t", it.tag, irq_out, it.exp, $time);
        end
      end
    end
  end

  task automatic summary();
    $display("  Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog (all requirements): finished=0 expected 1");
      summary();
      $finish;
    end
  end

  initial begin
    rst = 1'b1; cmd_valid = 0; cmd_op = 0; cmd_idx = 0; cmd_data = 0; irq_in = 0;
    m_en = 0; m_mask = '1; m_prev = '0;
    for (int i = 0; i < C; i++) begin
      m_dest[i] = '0; m_rot[i] = 0; m_ptr[i] = N - 1;
    end
    repeat (3) @(negedge clk);
    checks++;
    if (irq_out !== '0) begin
      errors++;
      $display("FAIL R1: irq_out=%h expected 0 in reset", irq_out);
    end
    rst = 1'b0;

    // R1: masked and disabled after reset
    cycle(3'd0, 0, 32'd0, 4'h0, "R1");
    hold(4'hF, 2, "R1");
    // R2: unmask and route, still disabled
    for (int i = 0; i < C; i++) cycle(3'd3, i, 32'd0, 4'hF, "R2");
    cycle(3'd1, 0, 32'h5, 4'hF, "R2");
    cycle(3'd1, 1, 32'h8, 4'hF, "R2");
    cycle(3'd1, 2, 32'hF, 4'hF, "R2");
    cycle(3'd1, 3, 32'h2, 4'hF, "R2");
    cycle(3'd4, 0, 32'd0, 4'hF, "R2");
    // R4: fixed routing
    hold(4'hF, 2, "R4");
    // R6: level follow
    hold(4'hE, 2, "R6");
    hold(4'hF, 1, "R6");
    // R3: mask and unmask source 1
    cycle(3'd3, 1, 32'd1, 4'hF, "R3");
    hold(4'hF, 2, "R3");
    cycle(3'd3, 1, 32'd0, 4'hF, "R3");
    hold(4'hF, 2, "R3");
    // R10: fixed-mode bitmask change while asserted
    cycle(3'd1, 2, 32'h3, 4'hF, "R10");
    hold(4'hF, 2, "R10");
    // R5: rotating mode selected with junk in the upper data bits
    cycle(3'd1, 2, 32'hF, 4'hB, "R5");
    cycle(3'd2, 2, 32'hFFFF_FFFD, 4'hB, "R5");
    // R7 / R8: pulse trains
    for (int p = 0; p < 6; p++) begin
      cycle(3'd0, 0, 32'd0, 4'hF, "R7");
      cycle(3'd0, 0, 32'd0, 4'hF, "R8");
      cycle(3'd0, 0, 32'd0, 4'hB, "R6");
    end
    // R9: empty bitmask
    cycle(3'd1, 2, 32'h0, 4'hB, "R9");
    for (int p = 0; p < 2; p++) begin
      hold(4'hF, 2, "R9");
      hold(4'hB, 1, "R9");
    end
    cycle(3'd1, 2, 32'h4, 4'hB, "R9");
    hold(4'hF, 2, "R9");
    hold(4'hB, 1, "R9");
    // R7: sparse bitmask with wrap
    cycle(3'd1, 2, 32'hA, 4'hB, "R7");
    for (int p = 0; p < 4; p++) begin
      hold(4'hF, 2, "R7");
      hold(4'hB, 1, "R7");
    end
    // R10: rotating source loses its held core
    hold(4'hF, 1, "R10");
    cycle(3'd1, 2, 32'h2, 4'hF, "R10");
    hold(4'hF, 2, "R10");
    cycle(3'd1, 2, 32'h8, 4'hF, "R10");
    hold(4'hF, 2, "R10");
    // R5: modes 2 and 3 behave as fixed
    cycle(3'd1, 3, 32'hD, 4'hF, "R5");
    cycle(3'd2, 3, 32'h0000_0012, 4'hF, "R5");
    hold(4'hF, 2, "R5");
    cycle(3'd2, 3, 32'hFFFF_FF13, 4'hF, "R5");
    hold(4'hF, 2, "R5");
    // R11: commands to source 0 leave the others alone
    cycle(3'd3, 0, 32'd1, 4'hF, "R11");
    cycle(3'd1, 0, 32'hF, 4'hF, "R11");
    cycle(3'd2, 0, 32'h1, 4'hF, "R11");
    hold(4'hF, 2, "R11");
    cycle(3'd3, 0, 32'd0, 4'h0, "R11");
    hold(4'h1, 2, "R11");
    hold(4'h0, 2, "R6");

    repeat (3) @(negedge clk);
    done = 1;
    summary();
    $finish;
  end

endmodule